// File: doc/BRIEF.md
# Ramped Supply Controller Command Decoder

This block sits on a crate dataway that carries a one-cycle command strobe, a 5-bit function code, a 4-bit subaddress, 16-bit write data, 16-bit read data and the two response flags X (command recognised) and Q (command accepted). It turns these commands into level outputs for a ramped power-supply controller. The outputs are supply on/off, polarity, ramp enable, energy-scaling enable, a one-cycle supply reset pulse and a 16-bit signed DAC setting. The block also holds the operating parameters: two scale factors, two slopes and a switch time. Finally it keeps a small table that maps clock events to ramp slots.

Set and clear actions come in pairs. Function 26 sets a control and function 24 clears it, and each control has its own subaddress. Parameters are written with function 17 and read back with function 1, using the same subaddress. A clock event assignment carries its slot number in the upper byte of the write word. The table is read back by one arming command followed by a run of sequential reads.

The response to a strobe appears one clock later. For that cycle the response-valid output is high, and X, Q and the read data are valid with it.

Top module: `ramp_supply_cmd`

## Requirements
- R1: After reset: supply_on=0, ramp_en=0, escale_en=0, pol_pos=1 and ps_rst_pulse=0. The DAC, every parameter and every table entry read 0, and resp_valid, resp_x and resp_q are 0.
- R2: Each strobe produces resp_valid=1 in the next cycle only. The implemented function/subaddress pairs are those listed in R3 to R12. They answer resp_x=1. Every other pair answers resp_x=0, resp_q=0 and rdata=0, and changes no output or stored value.
- R3: F26 A1 sets supply_on to 1. F24 A1 clears it to 0.
- R4: F26 A3 selects positive polarity (pol_pos=1). F24 A3 selects negative polarity (pol_pos=0).
- R5: F26 A2 sets ramp_en and F24 A2 clears it. F26 A4 sets escale_en and F24 A4 clears it.
- R6: F26 A7 raises ps_rst_pulse for exactly the one cycle in which its response is valid. It changes no other state.
- R7: F9 A0 returns every control output, parameter, DAC value, table entry and the readback pointer to the R1 values.
- R8: F16 A1 copies wdata to dac_value. Writing 0 gives dac_value=0.
- R9: F17 An writes wdata to a parameter, and F1 An returns that parameter on rdata. The subaddress selects it: 1 for the flat-top scale, 2 for the front-porch scale, 3 for the flat-top slope, 4 for the front-porch slope, 6 for the switch time.
- R10: F6 A1 returns the FW_VERSION parameter. F0 A0 returns ps_status as it was at the strobe edge.
- R11: F16 A6 stores wdata[7:0] as the event code for slot wdata[15:8], where slots are numbered 1 to NSLOTS. Slot k appears in evt_table[(k-1)*8 +: 8]. A slot number of 0 or above NSLOTS gives resp_q=0 and leaves the table unchanged.
- R12: F17 A14 arms readback at slot 1 and gives resp_q=1. Each following F0 A14 returns {slot number in bits 15:8, code in bits 7:0} and advances by one slot. Once NSLOTS entries have been read, or when readback is not armed, F0 A14 gives resp_q=0 and rdata=0.
- R13: Commands that are not reads (F24, F26, F9, F16, F17) return rdata=0 with resp_q=1, except the case given in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strb | input | 1 | Command strobe, one cycle per command |
| func | input | 5 | Function code |
| sub | input | 4 | Subaddress |
| wdata | input | 16 | Write data |
| ps_status | input | 16 | Live supply status word |
| rdata | output | 16 | Read data of the last command |
| resp_valid | output | 1 | Response flags and rdata are valid |
| resp_x | output | 1 | Command recognised |
| resp_q | output | 1 | Command accepted |
| supply_on | output | 1 | Supply enable level |
| pol_pos | output | 1 | 1 = positive polarity |
| ramp_en | output | 1 | Ramp enable level |
| escale_en | output | 1 | Energy-scaling enable level |
| ps_rst_pulse | output | 1 | One-cycle supply reset |
| dac_value | output | 16 | Signed DAC setting |
| ft_scale | output | 16 | Flat-top scale factor |
| fp_scale | output | 16 | Front-porch scale factor |
| ft_slope | output | 16 | Flat-top slope |
| fp_slope | output | 16 | Front-porch slope |
| sw_time | output | 16 | Scale-factor switch time |
| evt_table | output | 56 | Slot event codes, slot 1 in the low byte |

## Verification
The bench sweeps all 512 function/subaddress pairs. After each unimplemented pair it checks the full visible state. A decoder that matched too loosely, for example on the subaddress alone, would raise X there or change a control output. The slot table is exercised at slot numbers 0, NSLOTS+1 and 255; an off-by-one in the range check would write a neighbouring slot or silently drop slot NSLOTS. Readback is run past its end and then re-armed, which catches a pointer that wraps or never starts again. Card reset and the supply reset pulse are checked cycle by cycle. A pulse that lasted two cycles, or a card reset that missed the pointer or polarity, would show at the ports.

// File: rtl/ramp_supply_pkg.sv
package ramp_supply_pkg;

    localparam int FW = 5;
    localparam int AW = 4;
    localparam int EVW = 8;
    localparam int NPRM = 5;

    typedef enum logic [4:0] {
        CMD_NONE,
        CMD_SUP_OFF,
        CMD_SUP_ON,
        CMD_PS_RST,
        CMD_POL_POS,
        CMD_POL_NEG,
        CMD_RAMP_OFF,
        CMD_RAMP_ON,
        CMD_ESC_ON,
        CMD_ESC_OFF,
        CMD_CARD_RST,
        CMD_DAC_WR,
        CMD_PRM_WR,
        CMD_PRM_RD,
        CMD_FW_RD,
        CMD_STAT_RD,
        CMD_EVT_WR,
        CMD_EVT_ARM,
        CMD_EVT_RD
    } cmd_e;

    typedef enum logic [2:0] {
        PRM_FT_SCALE = 3'd0,
        PRM_FP_SCALE = 3'd1,
        PRM_FT_SLOPE = 3'd2,
        PRM_FP_SLOPE = 3'd3,
        PRM_SW_TIME  = 3'd4
    } prm_sel_e;

endpackage

// File: rtl/ramp_supply_decode.sv
module ramp_supply_decode
    import ramp_supply_pkg::*;
(
    input  logic          strb,
    input  logic [FW-1:0] func,
    input  logic [AW-1:0] sub,
    output cmd_e          cmd,
    output prm_sel_e      prm_sel,
    output logic          recognised
);

    prm_sel_e sel_c;
    logic     sel_ok_c;

    always_comb begin
        sel_c    = PRM_FT_SCALE;
        sel_ok_c = 1'b1;
        case (sub)
            4'd1:    sel_c = PRM_FT_SCALE;
            4'd2:    sel_c = PRM_FP_SCALE;
            4'd3:    sel_c = PRM_FT_SLOPE;
            4'd4:    sel_c = PRM_FP_SLOPE;
            4'd6:    sel_c = PRM_SW_TIME;
            default: sel_ok_c = 1'b0;
        endcase
    end

    always_comb begin
        cmd = CMD_NONE;
        if (strb) begin
            case (func)
                5'd24: begin
                    case (sub)
                        4'd1:    cmd = CMD_SUP_OFF;
                        4'd2:    cmd = CMD_RAMP_OFF;
                        4'd3:    cmd = CMD_POL_NEG;
                        4'd4:    cmd = CMD_ESC_OFF;
                        default: cmd = CMD_NONE;
                    endcase
                end
                5'd26: begin
                    case (sub)
                        4'd1:    cmd = CMD_SUP_ON;
                        4'd2:    cmd = CMD_RAMP_ON;
                        4'd3:    cmd = CMD_POL_POS;
                        4'd4:    cmd = CMD_ESC_ON;
                        4'd7:    cmd = CMD_PS_RST;
                        default: cmd = CMD_NONE;
                    endcase
                end
                5'd9: begin
                    if (sub == 4'd0) cmd = CMD_CARD_RST;
                end
                5'd16: begin
                    case (sub)
                        4'd1:    cmd = CMD_DAC_WR;
                        4'd6:    cmd = CMD_EVT_WR;
                        default: cmd = CMD_NONE;
                    endcase
                end
                5'd17: begin
                    if (sub == 4'd14)  cmd = CMD_EVT_ARM;
                    else if (sel_ok_c) cmd = CMD_PRM_WR;
                end
                5'd1: begin
                    if (sel_ok_c) cmd = CMD_PRM_RD;
                end
                5'd6: begin
                    if (sub == 4'd1) cmd = CMD_FW_RD;
                end
                5'd0: begin
                    case (sub)
                        4'd0:    cmd = CMD_STAT_RD;
                        4'd14:   cmd = CMD_EVT_RD;
                        default: cmd = CMD_NONE;
                    endcase
                end
                default: cmd = CMD_NONE;
            endcase
        end
    end

    assign prm_sel    = sel_c;
    assign recognised = (cmd != CMD_NONE);

endmodule

// File: rtl/ramp_supply_ctrl.sv
module ramp_supply_ctrl
    import ramp_supply_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd,
    output logic supply_on,
    output logic pol_pos,
    output logic ramp_en,
    output logic escale_en,
    output logic ps_rst_pulse
);

    typedef struct packed {
        logic sup;
        logic pol;
        logic ramp;
        logic esc;
        logic pulse;
    } ctrl_t;

    localparam ctrl_t CTRL_INIT = '{sup: 1'b0, pol: 1'b1, ramp: 1'b0, esc: 1'b0, pulse: 1'b0};

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.pulse = 1'b0;
        case (cmd)
            CMD_SUP_ON:   ctrl_d.sup   = 1'b1;
            CMD_SUP_OFF:  ctrl_d.sup   = 1'b0;
            CMD_POL_POS:  ctrl_d.pol   = 1'b1;
            CMD_POL_NEG:  ctrl_d.pol   = 1'b0;
            CMD_RAMP_ON:  ctrl_d.ramp  = 1'b1;
            CMD_RAMP_OFF: ctrl_d.ramp  = 1'b0;
            CMD_ESC_ON:   ctrl_d.esc   = 1'b1;
            CMD_ESC_OFF:  ctrl_d.esc   = 1'b0;
            CMD_PS_RST:   ctrl_d.pulse = 1'b1;
            CMD_CARD_RST: ctrl_d       = CTRL_INIT;
            default:      ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= CTRL_INIT;
        else        ctrl_q <= ctrl_d;
    end

    assign supply_on    = ctrl_q.sup;
    assign pol_pos      = ctrl_q.pol;
    assign ramp_en      = ctrl_q.ramp;
    assign escale_en    = ctrl_q.esc;
    assign ps_rst_pulse = ctrl_q.pulse;

    p_supply_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_SUP_ON) |=> supply_on);
    p_supply_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_SUP_OFF) |=> !supply_on);
    p_pulse_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_PS_RST) |=> !ps_rst_pulse);
    p_pulse_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PS_RST) |=> ($stable(supply_on) && $stable(ramp_en) && $stable(pol_pos)));
    p_card_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_CARD_RST) |=> (!supply_on && !ramp_en && !escale_en && pol_pos));

endmodule

// File: rtl/ramp_supply_params.sv
module ramp_supply_params
    import ramp_supply_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  cmd_e                     cmd,
    input  prm_sel_e                 prm_sel,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            prm_rd,
    output logic [NPRM-1:0][DW-1:0]  prm_out,
    output logic [DW-1:0]            dac_value
);

    typedef struct packed {
        logic [NPRM-1:0][DW-1:0] prm;
        logic [DW-1:0]           dac;
    } prm_state_t;

    prm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (cmd)
            CMD_DAC_WR: st_d.dac = wdata;
            CMD_PRM_WR: begin
                for (int i = 0; i < NPRM; i++) begin
                    if (int'(prm_sel) == i) st_d.prm[i] = wdata;
                end
            end
            CMD_CARD_RST: st_d = '0;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        prm_rd = '0;
        for (int i = 0; i < NPRM; i++) begin
            if (int'(prm_sel) == i) prm_rd = st_q.prm[i];
        end
    end

    assign prm_out   = st_q.prm;
    assign dac_value = st_q.dac;

    p_dac_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_DAC_WR) |=> (dac_value == $past(wdata)));
    p_prm_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NONE) |=> ($stable(prm_out) && $stable(dac_value)));

endmodule

// File: rtl/ramp_supply_evt.sv
module ramp_supply_evt
    import ramp_supply_pkg::*;
#(
    parameter int DW     = 16,
    parameter int NSLOTS = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  cmd_e                       cmd,
    input  logic [DW-1:0]              wdata,
    output logic                       evt_ok,
    output logic [DW-1:0]              evt_rd,
    output logic [NSLOTS-1:0][EVW-1:0] table_out
);

    localparam int PW = $clog2(NSLOTS + 2);

    typedef struct packed {
        logic [NSLOTS-1:0][EVW-1:0] tab;
        logic [PW-1:0]              ptr;
    } evt_state_t;

    evt_state_t st_d, st_q;

    logic [7:0] slot_c;
    logic       slot_ok_c;
    logic       ptr_ok_c;

    assign slot_c    = wdata[15:8];
    assign slot_ok_c = (slot_c != 8'd0) && (int'(slot_c) <= NSLOTS);
    assign ptr_ok_c  = (st_q.ptr != '0) && (int'(st_q.ptr) <= NSLOTS);

    always_comb begin
        evt_rd = '0;
        for (int k = 0; k < NSLOTS; k++) begin
            if (int'(st_q.ptr) == k + 1) evt_rd = {8'(k + 1), st_q.tab[k]};
        end
    end

    always_comb begin
        case (cmd)
            CMD_EVT_WR:  evt_ok = slot_ok_c;
            CMD_EVT_RD:  evt_ok = ptr_ok_c;
            CMD_EVT_ARM: evt_ok = 1'b1;
            default:     evt_ok = 1'b1;
        endcase
    end

    always_comb begin
        st_d = st_q;
        case (cmd)
            CMD_EVT_WR: begin
                for (int k = 0; k < NSLOTS; k++) begin
                    if (int'(slot_c) == k + 1) st_d.tab[k] = wdata[EVW-1:0];
                end
            end
            CMD_EVT_ARM: st_d.ptr = PW'(1);
            CMD_EVT_RD: begin
                if (ptr_ok_c) st_d.ptr = st_q.ptr + 1'b1;
            end
            CMD_CARD_RST: st_d = '0;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign table_out = st_q.tab;

    p_bad_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_EVT_WR) && !slot_ok_c) |=> $stable(table_out));
    p_ptr_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(st_q.ptr) <= NSLOTS + 1));
    p_arm_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_EVT_ARM) |=> (st_q.ptr == PW'(1)));

endmodule

// File: rtl/ramp_supply_cmd.sv
module ramp_supply_cmd
    import ramp_supply_pkg::*;
#(
    parameter int          DW         = 16,
    parameter int          NSLOTS     = 7,
    parameter logic [15:0] FW_VERSION = 16'h0203
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strb,
    input  logic [FW-1:0]         func,
    input  logic [AW-1:0]         sub,
    input  logic [DW-1:0]         wdata,
    input  logic [DW-1:0]         ps_status,
    output logic [DW-1:0]         rdata,
    output logic                  resp_valid,
    output logic                  resp_x,
    output logic                  resp_q,
    output logic                  supply_on,
    output logic                  pol_pos,
    output logic                  ramp_en,
    output logic                  escale_en,
    output logic                  ps_rst_pulse,
    output logic [DW-1:0]         dac_value,
    output logic [DW-1:0]         ft_scale,
    output logic [DW-1:0]         fp_scale,
    output logic [DW-1:0]         ft_slope,
    output logic [DW-1:0]         fp_slope,
    output logic [DW-1:0]         sw_time,
    output logic [NSLOTS*EVW-1:0] evt_table
);

    cmd_e                       cmd;
    prm_sel_e                   prm_sel;
    logic                       recognised;
    logic [DW-1:0]              prm_rd;
    logic [NPRM-1:0][DW-1:0]    prm_out;
    logic                       evt_ok;
    logic [DW-1:0]              evt_rd;
    logic [NSLOTS-1:0][EVW-1:0] tab;

    ramp_supply_decode u_decode (
        .strb       (strb),
        .func       (func),
        .sub        (sub),
        .cmd        (cmd),
        .prm_sel    (prm_sel),
        .recognised (recognised)
    );

    ramp_supply_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd          (cmd),
        .supply_on    (supply_on),
        .pol_pos      (pol_pos),
        .ramp_en      (ramp_en),
        .escale_en    (escale_en),
        .ps_rst_pulse (ps_rst_pulse)
    );

    ramp_supply_params #(.DW(DW)) u_params (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .prm_sel   (prm_sel),
        .wdata     (wdata),
        .prm_rd    (prm_rd),
        .prm_out   (prm_out),
        .dac_value (dac_value)
    );

    ramp_supply_evt #(.DW(DW), .NSLOTS(NSLOTS)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .wdata     (wdata),
        .evt_ok    (evt_ok),
        .evt_rd    (evt_rd),
        .table_out (tab)
    );

    typedef struct packed {
        logic          valid;
        logic          x;
        logic          q;
        logic [DW-1:0] rd;
    } resp_t;

    resp_t resp_d, resp_q_r;

    always_comb begin
        resp_d.valid = strb;
        resp_d.x     = recognised;
        resp_d.q     = recognised && evt_ok;
        case (cmd)
            CMD_PRM_RD:  resp_d.rd = prm_rd;
            CMD_FW_RD:   resp_d.rd = DW'(FW_VERSION);
            CMD_STAT_RD: resp_d.rd = ps_status;
            CMD_EVT_RD:  resp_d.rd = evt_ok ? evt_rd : '0;
            default:     resp_d.rd = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resp_q_r <= '0;
        else        resp_q_r <= resp_d;
    end

    assign resp_valid = resp_q_r.valid;
    assign resp_x     = resp_q_r.x;
    assign resp_q     = resp_q_r.q;
    assign rdata      = resp_q_r.rd;

    assign ft_scale  = prm_out[PRM_FT_SCALE];
    assign fp_scale  = prm_out[PRM_FP_SCALE];
    assign ft_slope  = prm_out[PRM_FT_SLOPE];
    assign fp_slope  = prm_out[PRM_FP_SLOPE];
    assign sw_time   = prm_out[PRM_SW_TIME];
    assign evt_table = tab;

    p_resp_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strb |=> resp_valid);
    p_resp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !strb |=> !resp_valid);
    p_x_zero_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_x) |-> (!resp_q && rdata == '0));
    p_flags_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> (!resp_x && !resp_q));

endmodule

// File: tb/ramp_supply_cmd_tb.sv
module ramp_supply_cmd_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 7;
    localparam logic [15:0] FWV = 16'h0203;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strb = 1'b0;
    logic [4:0]  func = '0;
    logic [3:0]  sub = '0;
    logic [15:0] wdata = '0;
    logic [15:0] ps_status = '0;
    logic [15:0] rdata;
    logic        resp_valid, resp_x, resp_q;
    logic        supply_on, pol_pos, ramp_en, escale_en, ps_rst_pulse;
    logic [15:0] dac_value, ft_scale, fp_scale, ft_slope, fp_slope, sw_time;
    logic [NS*8-1:0] evt_table;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic        e_sup, e_pol, e_ramp, e_esc;
    logic [15:0] e_dac;
    logic [15:0] e_prm [5];
    logic [7:0]  e_tab [NS];

    always #(CLK_PERIOD/2) clk = ~clk;

    ramp_supply_cmd #(.DW(16), .NSLOTS(NS), .FW_VERSION(FWV)) dut_i (
        .clk(clk), .rst_n(rst_n), .strb(strb), .func(func), .sub(sub),
        .wdata(wdata), .ps_status(ps_status), .rdata(rdata),
        .resp_valid(resp_valid), .resp_x(resp_x), .resp_q(resp_q),
        .supply_on(supply_on), .pol_pos(pol_pos), .ramp_en(ramp_en),
        .escale_en(escale_en), .ps_rst_pulse(ps_rst_pulse),
        .dac_value(dac_value), .ft_scale(ft_scale), .fp_scale(fp_scale),
        .ft_slope(ft_slope), .fp_slope(fp_slope), .sw_time(sw_time),
        .evt_table(evt_table)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cmd(input int f, input int a, input logic [15:0] w);
        @(negedge clk);
        strb = 1'b1; func = 5'(f); sub = 4'(a); wdata = w;
        @(negedge clk);
        strb = 1'b0;
    endtask

    function automatic bit impl(input int f, input int a);
        bit prm_a = (a == 1 || a == 2 || a == 3 || a == 4 || a == 6);
        return ((f == 24 || f == 26) && a >= 1 && a <= 4) || (f == 26 && a == 7) ||
               (f == 9 && a == 0) || (f == 16 && (a == 1 || a == 6)) ||
               ((f == 17 || f == 1) && prm_a) || (f == 17 && a == 14) ||
               (f == 6 && a == 1) || (f == 0 && (a == 0 || a == 14));
    endfunction

    function automatic int prm_idx(input int a);
        return (a == 6) ? 4 : a - 1;
    endfunction

    task automatic model_reset();
        e_sup = 0; e_pol = 1; e_ramp = 0; e_esc = 0; e_dac = '0;
        for (int i = 0; i < 5; i++) e_prm[i] = '0;
        for (int k = 0; k < NS; k++) e_tab[k] = '0;
    endtask

    task automatic check_state(input string tag);
        chk({tag, " supply_on"}, 32'(supply_on), 32'(e_sup));
        chk({tag, " pol_pos"},   32'(pol_pos),   32'(e_pol));
        chk({tag, " ramp_en"},   32'(ramp_en),   32'(e_ramp));
        chk({tag, " escale_en"}, 32'(escale_en), 32'(e_esc));
        chk({tag, " dac"},       32'(dac_value), 32'(e_dac));
        chk({tag, " ft_scale"},  32'(ft_scale),  32'(e_prm[0]));
        chk({tag, " fp_scale"},  32'(fp_scale),  32'(e_prm[1]));
        chk({tag, " ft_slope"},  32'(ft_slope),  32'(e_prm[2]));
        chk({tag, " fp_slope"},  32'(fp_slope),  32'(e_prm[3]));
        chk({tag, " sw_time"},   32'(sw_time),   32'(e_prm[4]));
        for (int k = 0; k < NS; k++)
            chk({tag, " evt_table"}, 32'(evt_table[k*8 +: 8]), 32'(e_tab[k]));
    endtask

    task automatic resp(input string tag, input bit x, input bit q, input logic [15:0] rd);
        chk({tag, " valid"}, 32'(resp_valid), 32'd1);
        chk({tag, " x"},     32'(resp_x),     32'(x));
        chk({tag, " q"},     32'(resp_q),     32'(q));
        chk({tag, " rdata"}, 32'(rdata),      32'(rd));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        check_state("R1");
        chk("R1 valid", 32'(resp_valid), 0);
        chk("R1 x", 32'(resp_x), 0);
        chk("R1 q", 32'(resp_q), 0);
        chk("R1 pulse", 32'(ps_rst_pulse), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R1 post");

        // R3 supply on/off, R13 zero read data on writes
        cmd(26, 1, 16'hFFFF); e_sup = 1; resp("R3 on R13", 1, 1, 0); check_state("R3 on");
        @(negedge clk);
        chk("R2 valid drops", 32'(resp_valid), 0);
        cmd(24, 1, 0); e_sup = 0; resp("R3 off", 1, 1, 0); check_state("R3 off");
        cmd(26, 1, 0); e_sup = 1;
        // R4 polarity
        cmd(24, 3, 0); e_pol = 0; resp("R4 neg", 1, 1, 0); check_state("R4 neg");
        cmd(26, 3, 0); e_pol = 1; check_state("R4 pos");
        cmd(24, 3, 0); e_pol = 0;
        // R5 ramp and energy scaling
        cmd(26, 2, 0); e_ramp = 1; check_state("R5 ramp on");
        cmd(24, 2, 0); e_ramp = 0; check_state("R5 ramp off");
        cmd(26, 2, 0); e_ramp = 1;
        cmd(26, 4, 0); e_esc = 1; check_state("R5 esc on");
        cmd(24, 4, 0); e_esc = 0; check_state("R5 esc off");
        cmd(26, 4, 0); e_esc = 1;
        // R6 reset pulse
        cmd(26, 7, 0); resp("R6", 1, 1, 0);
        chk("R6 pulse high", 32'(ps_rst_pulse), 1); check_state("R6 quiet");
        @(negedge clk);
        chk("R6 pulse one cycle", 32'(ps_rst_pulse), 0);
        // R8 DAC
        cmd(16, 1, 16'h8001); e_dac = 16'h8001; resp("R8 R13", 1, 1, 0); check_state("R8");
        cmd(16, 1, 16'h0000); e_dac = 16'h0000; check_state("R8 zero");
        cmd(16, 1, 16'h7FFE); e_dac = 16'h7FFE;
        // R9 parameters
        for (int a = 1; a <= 6; a++) begin
            if (a == 5) continue;
            cmd(17, a, 16'(16'h1000 + a * 16'h0111));
            e_prm[prm_idx(a)] = 16'(16'h1000 + a * 16'h0111);
            resp("R9 write", 1, 1, 0);
        end
        check_state("R9 outputs");
        for (int a = 1; a <= 6; a++) begin
            if (a == 5) continue;
            cmd(1, a, 16'hDEAD);
            resp("R9 read", 1, 1, e_prm[prm_idx(a)]);
        end
        // R10 firmware and status
        cmd(6, 1, 0); resp("R10 fw", 1, 1, FWV);
        ps_status = 16'hA5C3; cmd(0, 0, 0); resp("R10 status", 1, 1, 16'hA5C3);
        ps_status = 16'h0F0F; cmd(0, 0, 0); resp("R10 status2", 1, 1, 16'h0F0F);
        // R12 read before arming
        cmd(0, 14, 0); resp("R12 unarmed", 1, 0, 0);
        // R11 slot writes
        for (int k = 1; k <= NS; k++) begin
            cmd(16, 6, {8'(k), 8'(8'h30 + k * 8'h11)});
            e_tab[k-1] = 8'(8'h30 + k * 8'h11);
            resp("R11 write", 1, 1, 0);
        end
        check_state("R11 table");
        cmd(16, 6, {8'd0, 8'hEE}); resp("R11 slot0", 1, 0, 0); check_state("R11 slot0");
        cmd(16, 6, {8'(NS + 1), 8'hEE}); resp("R11 slot high", 1, 0, 0); check_state("R11 high");
        cmd(16, 6, {8'd255, 8'hEE}); resp("R11 slot255", 1, 0, 0); check_state("R11 255");
        // R12 readback
        cmd(17, 14, 0); resp("R12 arm", 1, 1, 0);
        for (int k = 1; k <= NS; k++) begin
            cmd(0, 14, 0);
            resp("R12 seq", 1, 1, {8'(k), e_tab[k-1]});
        end
        cmd(0, 14, 0); resp("R12 past end", 1, 0, 0);
        cmd(0, 14, 0); resp("R12 past end2", 1, 0, 0);
        cmd(17, 14, 0); cmd(0, 14, 0); resp("R12 rearm", 1, 1, {8'd1, e_tab[0]});
        // R2 sweep of unimplemented pairs
        for (int f = 0; f < 32; f++) begin
            for (int a = 0; a < 16; a++) begin
                if (impl(f, a)) continue;
                cmd(f, a, 16'hFFFF);
                resp("R2 unimpl", 0, 0, 0);
                chk("R2 no pulse", 32'(ps_rst_pulse), 0);
                check_state("R2 unimpl state");
            end
        end
        // readback pointer untouched by sweep: next entry is slot 2
        cmd(0, 14, 0); resp("R2 ptr kept", 1, 1, {8'd2, e_tab[1]});
        // R7 card reset
        cmd(9, 0, 16'h1234); model_reset(); resp("R7", 1, 1, 0); check_state("R7");
        cmd(0, 14, 0); resp("R7 ptr cleared", 1, 0, 0);
        cmd(1, 6, 0); resp("R7 prm read", 1, 1, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule